// File: doc/BRIEF.md
# Four-Channel DAC Test Waveform Sequencer

The sequencer generates four test waveforms for a four-output digital-to-analogue converter. Each output is refreshed at a fixed sample rate. An external sample tick starts a refresh. The block then requests four frames from an external frame writer, one per channel, in the fixed order 0, 1, 2, 3. Each frame carries a channel number and a 12-bit code. The writer answers every frame with a done pulse and the 32-bit word that the converter shifted back. That word is the previous command.

After the fourth frame completes, the block computes the codes for the next tick:

- Channel 1 is a triangle.
- Channel 2 is a two-level square wave.
- Channel 3 is an external signed sine sample, rescaled to an unsigned mid-rail code.
- Channel 0 is rebuilt from the echo of the channel 2 command, so it trails channel 2 by one sample.

A 16-bit count of accepted ticks drives eight indicator lights. At power-up the block holds the converter clear line for a fixed number of cycles. It accepts no tick until that time has passed.

Top module: `wavetest_dac_sequencer`

## Requirements
- R1: After reset is released, `dac_clr_o` stays high for exactly CLR_CYCLES clock edges, then falls. A tick during that time causes no frame and no overrun.
- R2: Each accepted tick produces exactly four `wr_req_o` pulses, each one cycle long. `wr_chan_o` is 0, 1, 2, 3 in that order. A new request is raised only after `wr_done_i` has answered the previous one.
- R3: The first tick after reset sends code 0 on all four channels.
- R4: The channel 1 code rises by 204 per update from 0. It turns downward when the new value equals exactly 4080. It falls by 204 until the new value equals exactly 0, then turns upward. This gives a 40-tick period.
- R5: The channel 2 code is 0x333 when bit 1 of the accepted-tick count (before this tick's increment) is 0, and 0xCCD when that bit is 1.
- R6: The channel 0 code equals `rd_word_i[15:4]` as returned with the done pulse of the channel 3 frame, which is the echo of the channel 2 command.
- R7: The channel 3 code is the 16-bit two's-complement `sine_i` divided by 8 (arithmetic shift), plus 0x800, modulo 4096.
- R8: All new codes are computed once, after the fourth done pulse. They appear in the frames of the following tick, never in the current one.
- R9: The accepted-tick count increments by one per accepted tick, and `led_o` shows its upper eight bits.
- R10: A tick that arrives while frames are still pending or being computed raises `overrun_o` for one cycle, on the edge after the tick. That tick is dropped: it sends no frames and does not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Sample tick, one cycle per sample period |
| sine_i | input | 16 | Signed sine sample, read once per update |
| wr_done_i | input | 1 | Frame writer has finished the current frame |
| rd_word_i | input | 32 | Word echoed by the converter, valid with `wr_done_i` |
| dac_clr_o | output | 1 | Converter clear, high during the power-up window |
| wr_req_o | output | 1 | One-cycle request to send a frame |
| wr_chan_o | output | 2 | Channel number of the requested frame |
| wr_code_o | output | 12 | Code of the requested frame |
| led_o | output | 8 | Upper byte of the accepted-tick count |
| overrun_o | output | 1 | Pulse: a tick arrived while busy and was dropped |

## Verification
The main path is driven with two kinds of tick sequence. The first is a table of signed sine samples, which includes both rails, ±8, zero and an arbitrary value. The table shows whether the sign handling and the mid-rail offset on channel 3 are right. It also shows whether the sample is taken at the update rather than at the tick. The second is a long run of plain ticks, covering more than seven triangle periods and 256 ticks. It exposes off-by-one errors in the triangle turn points, in the square phase and in the one-sample lag of channel 0, and it moves the indicator byte. A converter echo model in the frame writer separates a correct channel 0 from one captured after the wrong frame. Directed ticks inside the clear window and during busy frames show whether they are really ignored.

// File: rtl/wtg_pkg.sv
package wtg_pkg;

    localparam int CODE_W  = 12;
    localparam int CHAN_N  = 4;
    localparam int CHAN_W  = $clog2(CHAN_N);
    localparam int SINE_W  = 16;
    localparam int SINE_SH = SINE_W - 1 - CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CHAN_W-1:0] chan_t;

    typedef enum logic [2:0] {
        SQ_CLEAR,
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_UPDATE
    } seq_state_e;

    // codes held for the next tick (channel 1 lives in the triangle unit)
    typedef struct packed {
        code_t echo;
        code_t square;
        code_t sine;
    } held_codes_t;

    localparam code_t MID_CODE = code_t'(1 << (CODE_W - 1));

    // signed sample -> unsigned code centred on mid-rail
    function automatic code_t sine_to_code(input logic [SINE_W-1:0] s);
        logic signed [SINE_W-1:0] sh;
        sh = $signed(s) >>> SINE_SH;
        return code_t'(sh[CODE_W-1:0] + MID_CODE);
    endfunction

endpackage

// File: rtl/wtg_seq_fsm.sv
module wtg_seq_fsm
    import wtg_pkg::*;
#(
    parameter int CLR_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  wr_done_i,
    output logic  dac_clr_o,
    output logic  wr_req_o,
    output chan_t chan_o,
    output logic  update_o,
    output logic  echo_cap_o,
    output logic  overrun_o
);

    localparam int    CLR_W     = $clog2(CLR_CYCLES + 1);
    localparam chan_t LAST_CHAN = chan_t'(CHAN_N - 1);

    seq_state_e       state_q;
    logic [CLR_W-1:0] clr_cnt_q;
    chan_t            idx_q;
    logic             ovr_q;
    logic             busy;

    assign busy = (state_q == SQ_ISSUE) || (state_q == SQ_WAIT) || (state_q == SQ_UPDATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_CLEAR;
            clr_cnt_q <= '0;
            idx_q     <= '0;
            ovr_q     <= 1'b0;
        end else begin
            ovr_q <= tick_i && busy;
            case (state_q)
                SQ_CLEAR: begin
                    if (clr_cnt_q == CLR_W'(CLR_CYCLES - 1)) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        clr_cnt_q <= clr_cnt_q + 1'b1;
                    end
                end
                SQ_IDLE: begin
                    if (tick_i) begin
                        idx_q   <= '0;
                        state_q <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (wr_done_i) begin
                        if (idx_q == LAST_CHAN) begin
                            state_q <= SQ_UPDATE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SQ_ISSUE;
                        end
                    end
                end
                SQ_UPDATE: state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    assign dac_clr_o  = (state_q == SQ_CLEAR);
    assign wr_req_o   = (state_q == SQ_ISSUE);
    assign chan_o     = idx_q;
    assign update_o   = (state_q == SQ_UPDATE);
    assign echo_cap_o = (state_q == SQ_WAIT) && wr_done_i && (idx_q == LAST_CHAN);
    assign overrun_o  = ovr_q;

endmodule

// File: rtl/wtg_triangle.sv
module wtg_triangle
    import wtg_pkg::*;
#(
    parameter int STEP = 204,
    parameter int PEAK = 4080
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step_i,
    output code_t value_o
);

    localparam code_t STEP_C = code_t'(STEP);
    localparam code_t PEAK_C = code_t'(PEAK);

    code_t value_q;
    logic  down_q;
    code_t next_val;

    always_comb begin
        if (down_q) begin
            next_val = value_q - STEP_C;
        end else begin
            next_val = value_q + STEP_C;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            down_q  <= 1'b0;
        end else if (step_i) begin
            value_q <= next_val;
            // reversal only on exact arrival at a turn point
            if (!down_q && next_val == PEAK_C) begin
                down_q <= 1'b1;
            end else if (down_q && next_val == '0) begin
                down_q <= 1'b0;
            end
        end
    end

    assign value_o = value_q;

endmodule

// File: rtl/wtg_sample_counter.sv
module wtg_sample_counter #(
    parameter int CNT_W  = 16,
    parameter int LED_W  = 8,
    parameter int SQ_BIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic             sq_sel_o,
    output logic [LED_W-1:0] led_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sq_sel_o = cnt_q[SQ_BIT];
    assign led_o    = cnt_q[CNT_W-1 -: LED_W];

endmodule

// File: rtl/wavetest_dac_sequencer.sv
module wavetest_dac_sequencer
    import wtg_pkg::*;
#(
    parameter int                  CLR_CYCLES = 4,
    parameter int                  TRI_STEP   = 204,
    parameter int                  TRI_PEAK   = 4080,
    parameter logic [CODE_W-1:0]   SQ_LOW     = 12'h333,
    parameter logic [CODE_W-1:0]   SQ_HIGH    = 12'hCCD,
    parameter int                  CNT_W      = 16,
    parameter int                  LED_W      = 8,
    parameter int                  ECHO_LSB   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [SINE_W-1:0] sine_i,
    input  logic              wr_done_i,
    input  logic [31:0]       rd_word_i,
    output logic              dac_clr_o,
    output logic              wr_req_o,
    output logic [CHAN_W-1:0] wr_chan_o,
    output logic [CODE_W-1:0] wr_code_o,
    output logic [LED_W-1:0]  led_o,
    output logic              overrun_o
);

    logic        update;
    logic        echo_cap;
    logic        sq_sel;
    chan_t       chan;
    code_t       tri_code;
    code_t       echo_q;
    held_codes_t held_q;
    logic        unused_rd_bits;

    assign unused_rd_bits = ^{rd_word_i[31:ECHO_LSB+CODE_W], rd_word_i[ECHO_LSB-1:0]};

    wtg_seq_fsm #(
        .CLR_CYCLES(CLR_CYCLES)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .wr_done_i (wr_done_i),
        .dac_clr_o (dac_clr_o),
        .wr_req_o  (wr_req_o),
        .chan_o    (chan),
        .update_o  (update),
        .echo_cap_o(echo_cap),
        .overrun_o (overrun_o)
    );

    wtg_triangle #(
        .STEP(TRI_STEP),
        .PEAK(TRI_PEAK)
    ) tri_i (
        .clk    (clk),
        .rst    (rst),
        .step_i (update),
        .value_o(tri_code)
    );

    wtg_sample_counter #(
        .CNT_W (CNT_W),
        .LED_W (LED_W),
        .SQ_BIT(1)
    ) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (update),
        .sq_sel_o(sq_sel),
        .led_o   (led_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_q <= '0;
            held_q <= '0;
        end else begin
            if (echo_cap) begin
                echo_q <= rd_word_i[ECHO_LSB +: CODE_W];
            end
            if (update) begin
                held_q.echo   <= echo_q;
                held_q.square <= sq_sel ? SQ_HIGH : SQ_LOW;
                held_q.sine   <= sine_to_code(sine_i);
            end
        end
    end

    always_comb begin
        case (chan)
            2'd0:    wr_code_o = held_q.echo;
            2'd1:    wr_code_o = tri_code;
            2'd2:    wr_code_o = held_q.square;
            default: wr_code_o = held_q.sine;
        endcase
    end

    assign wr_chan_o = chan;

endmodule

// File: rtl/wavetest_dac_sequencer_chk.sv
module wavetest_dac_sequencer_chk #(
    parameter int          TRI_PEAK = 4080,
    parameter logic [11:0] SQ_LOW   = 12'h333,
    parameter logic [11:0] SQ_HIGH  = 12'hCCD
) (
    input logic        clk,
    input logic        rst,
    input logic        tick_i,
    input logic        dac_clr_o,
    input logic        wr_req_o,
    input logic [1:0]  wr_chan_o,
    input logic [11:0] wr_code_o,
    input logic [7:0]  led_o,
    input logic        overrun_o
);

    a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |=> !wr_req_o);

    a_r1_quiet_clear: assert property (@(posedge clk) disable iff (rst)
        dac_clr_o |-> (!wr_req_o && !overrun_o));

    a_r10_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> $past(tick_i));

    a_r9_led_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(led_o) |-> (led_o == 8'($past(led_o) + 8'd1)));

    a_r4_tri_range: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_chan_o == 2'd1) |-> (wr_code_o <= 12'(TRI_PEAK)));

    a_r5_square_levels: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_chan_o == 2'd2) |->
            (wr_code_o == SQ_LOW || wr_code_o == SQ_HIGH || wr_code_o == 12'd0));

endmodule

bind wavetest_dac_sequencer wavetest_dac_sequencer_chk #(
    .TRI_PEAK(TRI_PEAK),
    .SQ_LOW  (SQ_LOW),
    .SQ_HIGH (SQ_HIGH)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .dac_clr_o(dac_clr_o),
    .wr_req_o (wr_req_o),
    .wr_chan_o(wr_chan_o),
    .wr_code_o(wr_code_o),
    .led_o    (led_o),
    .overrun_o(overrun_o)
);

// File: tb/wavetest_dac_sequencer_tb_top.sv
module wavetest_dac_sequencer_tb_top;

    localparam int WR_LAT     = 3;
    localparam int TICK_GAP   = 48;
    localparam int CLR_CYCLES = 4;
    localparam int N_TAB      = 8;
    localparam int N_TICKS    = 300;

    // {sine sample, expected channel 3 code}
    localparam logic [27:0] TAB [N_TAB] = '{
        {16'h0000, 12'h800},
        {16'h2400, 12'hC80},
        {16'hDC00, 12'h380},
        {16'h3FF8, 12'hFFF},
        {16'hC000, 12'h000},
        {16'h0008, 12'h801},
        {16'hFFF8, 12'h7FF},
        {16'h1234, 12'hA46}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [15:0] sine_i = '0;
    logic        wr_done_i = 1'b0;
    logic [31:0] rd_word_i = '0;
    logic        dac_clr_o;
    logic        wr_req_o;
    logic [1:0]  wr_chan_o;
    logic [11:0] wr_code_o;
    logic [7:0]  led_o;
    logic        overrun_o;

    always #10 clk = ~clk;

    wavetest_dac_sequencer #(.CLR_CYCLES(CLR_CYCLES)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .sine_i   (sine_i),
        .wr_done_i(wr_done_i),
        .rd_word_i(rd_word_i),
        .dac_clr_o(dac_clr_o),
        .wr_req_o (wr_req_o),
        .wr_chan_o(wr_chan_o),
        .wr_code_o(wr_code_o),
        .led_o    (led_o),
        .overrun_o(overrun_o)
    );

    int checks = 0;
    int fails  = 0;

    // frame writer with converter echo behaviour
    int          fcnt = 0;
    int          pend = 0;
    int          proto_err = 0;
    int          ovr_seen = 0;
    logic [1:0]  ring_chan [16];
    logic [11:0] ring_code [16];
    logic [31:0] cur_w = '0;
    logic [31:0] echo_w = '0;

    always @(negedge clk) begin
        wr_done_i <= 1'b0;
        if (!rst) begin
            if (overrun_o) ovr_seen++;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    wr_done_i <= 1'b1;
                    rd_word_i <= echo_w;
                    echo_w = cur_w;
                end
            end
            if (wr_req_o) begin
                if (pend != 0) proto_err++;
                ring_chan[fcnt % 16] = wr_chan_o;
                ring_code[fcnt % 16] = wr_code_o;
                fcnt++;
                cur_w = {8'h00, 4'h3, 2'b00, wr_chan_o, wr_code_o, 4'h0};
                pend = WR_LAT;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // reference model
    int mcode [4] = '{0, 0, 0, 0};
    int mdown = 0;
    int mcnt = 0;

    task automatic model_update(input int exp_d);
        int sent_c;
        sent_c = mcode[2];
        mcode[0] = sent_c;
        if (mdown == 0) begin
            mcode[1] = mcode[1] + 204;
            if (mcode[1] == 4080) mdown = 1;
        end else begin
            mcode[1] = mcode[1] - 204;
            if (mcode[1] == 0) mdown = 0;
        end
        mcode[2] = ((mcnt >> 1) & 1) != 0 ? 12'hCCD : 12'h333;
        mcode[3] = exp_d;
        mcnt++;
    endtask

    task automatic run_tick(input logic [15:0] s, input int exp_d, input bit first);
        int base;
        base = fcnt;
        sine_i = s;
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R10 no overrun when idle", int'(overrun_o), 0);
        repeat (TICK_GAP) @(negedge clk);
        chk("R2 four frames per tick", fcnt - base, 4);
        for (int j = 0; j < 4; j++) begin
            chk("R2 channel order", int'(ring_chan[(base + j) % 16]), j);
            if (first) begin
                chk("R3 reset codes", int'(ring_code[(base + j) % 16]), 0);
            end else begin
                case (j)
                    0: chk("R6 echo of channel 2", int'(ring_code[(base + j) % 16]), mcode[0]);
                    1: chk("R4 triangle", int'(ring_code[(base + j) % 16]), mcode[1]);
                    2: chk("R5 square", int'(ring_code[(base + j) % 16]), mcode[2]);
                    default: chk("R7 R8 sine code", int'(ring_code[(base + j) % 16]), mcode[3]);
                endcase
            end
        end
        model_update(exp_d);
        chk("R9 led byte", int'(led_o), (mcnt >> 8) & 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        int n;
        int base;
        repeat (3) @(negedge clk);
        chk("R1 clear high in reset", int'(dac_clr_o), 1);
        chk("R2 no request in reset", int'(wr_req_o), 0);
        chk("R9 led reset", int'(led_o), 0);
        rst = 1'b0;
        n = 0;
        while (dac_clr_o && n < 100) begin
            n++;
            tick_i = (n == 2);
            @(negedge clk);
        end
        tick_i = 1'b0;
        chk("R1 clear window length", n, CLR_CYCLES);
        repeat (10) @(negedge clk);
        chk("R1 tick in clear sends nothing", fcnt, 0);
        chk("R1 tick in clear no overrun", ovr_seen, 0);
        chk("R9 tick in clear not counted", int'(led_o), 0);

        // table of sine samples
        for (int i = 0; i < N_TAB; i++) begin
            run_tick(TAB[i][27:12], int'(TAB[i][11:0]), i == 0);
        end
        // long run across triangle periods and the led byte
        for (int k = N_TAB; k < N_TICKS; k++) begin
            run_tick(16'h0000, 12'h800, 1'b0);
        end
        chk("R9 led after run", int'(led_o), 1);

        // busy tick is dropped
        base = fcnt;
        n = ovr_seen;
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        repeat (4) @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R10 overrun raised", int'(overrun_o), 1);
        @(negedge clk);
        chk("R10 overrun one cycle", int'(overrun_o), 0);
        repeat (TICK_GAP) @(negedge clk);
        chk("R10 dropped tick sends nothing", fcnt - base, 4);
        chk("R10 single overrun", ovr_seen - n, 1);
        model_update(12'h800);
        // phase of square and triangle show whether the dropped tick counted
        for (int k = 0; k < 4; k++) begin
            run_tick(16'h0000, 12'h800, 1'b0);
        end
        chk("R2 protocol", proto_err, 0);

        report();
        $finish;
    end

endmodule